// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block sits in the decode stage of a five-stage in-order pipeline. It picks the two values that get latched into the ALU input registers A and B for the instruction now being decoded. Each source index is compared with the destination of the instruction in the memory stage and with the destination of the instruction in the write-back stage. When one of those older instructions is about to write the register being read, its value is taken from the pipe. Otherwise the register-file read data is used.

The memory-stage candidate is the ALU result register. The write-back-stage candidate depends on what that instruction is:

- For arithmetic, set, link and move-from-special instructions, it is the preserved copy of the ALU result.
- For a load, it is the load-data register after byte or halfword extraction.

Only register-writing instructions count as producers. A producer whose destination is register 0, or a bubble, never forwards. A link instruction always writes the highest register.

A thin set of stage registers is wrapped around the selector so that it can be driven one cycle at a time. Each cycle one instruction is presented at decode. The bench supplies:

- the register-file read data for that instruction's sources;
- the ALU result of the instruction in the execute stage;
- the raw memory word of the instruction in the memory stage.

The block exposes the latched A and B values and the write-back port. The ALU, the register file and stall generation live elsewhere. A load that is still in the memory stage when a dependent instruction decodes is assumed to have been separated by stall logic.

Top module: `opsel_stage_top`

## Requirements
- R1: While rst_n is low at a clock edge, opa, opb and wb_we are 0 after that edge.
- R2: If the instruction two slots older (now in the memory stage) is a non-load register writer whose effective destination equals a source index, the matching output takes that instruction's ALU result. That result is the ex_result value driven one cycle after the instruction was presented.
- R3: If only the write-back-stage instruction (three slots older) writes the source register, the output takes that instruction's write-back value.
- R4: When both the memory-stage and write-back-stage instructions write the source register, the memory-stage (younger) value wins.
- R5: A write-back-stage instruction of class ALU (0), SET (1) or MOVE-FROM-SPECIAL (4) drives wb_we=1, wb_idx=its destination field and wb_data=its ALU result.
- R6: For a write-back-stage LOAD (class 2), the write-back value is the raw memory word after extraction by the load kind in id_ldk. Kind 1 sign-extends bits 15:0, kind 2 zero-extends bits 15:0, kind 3 sign-extends bits 7:0 and kind 4 zero-extends bits 7:0. Kinds 0 and 5 to 7 pass the whole word.
- R7: With no matching producer, opa/opb equal the rf_rd1/rf_rd2 value presented with the instruction.
- R8: Bubbles (id_valid=0) and non-writing classes (5 to 15) never cause a bypass and never raise wb_we, whatever their destination field.
- R9: A producer with effective destination 0 never bypasses and never raises wb_we, and a source index of 0 always takes the register-file value.
- R10: A LINK (class 3) writes register NREG-1 whatever its destination field holds, and it forwards under that index.
- R11: An instruction is latched to opa/opb at the first edge after it is presented. Its write-back appears on the wb port three cycles after presentation.
- R12: The instruction one slot older (in the execute stage) is not forwarded, so the output holds the value written by older instructions only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode slot holds a real instruction |
| id_cls | input | 4 | Instruction class code |
| id_ldk | input | 3 | Load extraction kind |
| id_dst | input | AW | Destination register field |
| id_src1 | input | AW | First source register index |
| id_src2 | input | AW | Second source register index |
| rf_rd1 | input | XLEN | Register-file value of id_src1 |
| rf_rd2 | input | XLEN | Register-file value of id_src2 |
| ex_result | input | XLEN | ALU result of the execute-stage instruction |
| mem_rdata | input | XLEN | Raw memory word of the memory-stage instruction |
| opa | output | XLEN | Latched first ALU operand |
| opb | output | XLEN | Latched second ALU operand |
| wb_we | output | 1 | Register-file write enable |
| wb_idx | output | AW | Register-file write index |
| wb_data | output | XLEN | Register-file write data |

## Verification
The bench builds the block with XLEN=24 and NREG=8. With eight registers, random source indices collide often with the destinations of the three older slots, so single-stage, double-stage and execute-stage-only matches all occur many times. The link register becomes 7, which random destination fields seldom name, so the forced index is exercised apart from the field. A 24-bit word keeps the halfword and byte extractions distinct both from each other and from the full word.

// File: rtl/opsel_pkg.sv
// Shared class and load-kind codes for the decode-stage bypass selector.
// Assumes a 4-bit class field and a 3-bit load-kind field.
package opsel_pkg;

    typedef enum logic [3:0] {
        CL_ALU    = 4'd0,
        CL_SET    = 4'd1,
        CL_LOAD   = 4'd2,
        CL_LINK   = 4'd3,
        CL_MFS    = 4'd4,
        CL_STORE  = 4'd5,
        CL_BRANCH = 4'd6,
        CL_JUMP   = 4'd7,
        CL_MTS    = 4'd8
    } op_class_e;

    localparam logic [2:0] LK_WORD   = 3'd0;
    localparam logic [2:0] LK_HALF_S = 3'd1;
    localparam logic [2:0] LK_HALF_U = 3'd2;
    localparam logic [2:0] LK_BYTE_S = 3'd3;
    localparam logic [2:0] LK_BYTE_U = 3'd4;

    // True for the classes that write the register file.
    function automatic logic writes_reg(input op_class_e c);
        case (c)
            CL_ALU, CL_SET, CL_LOAD, CL_LINK, CL_MFS: writes_reg = 1'b1;
            default:                                  writes_reg = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/opsel_producer.sv
// Qualifies one pipeline slot as a register producer.
// Gives the effective destination: link is forced to the top register.
// Destination 0, bubbles and non-writing classes give wr_en = 0.
module opsel_producer
    import opsel_pkg::*;
#(
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic          valid,
    input  logic [3:0]    cls,
    input  logic [AW-1:0] dst,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic          is_load
);

    localparam logic [AW-1:0] LINK_IDX = AW'(NREG - 1);

    op_class_e cls_e;

    // Decode the class and derive the write qualification.
    always_comb begin
        cls_e   = op_class_e'(cls);
        wr_idx  = (cls_e == CL_LINK) ? LINK_IDX : dst;
        wr_en   = valid && writes_reg(cls_e) && (wr_idx != '0);
        is_load = valid && (cls_e == CL_LOAD);
    end

endmodule

// File: rtl/opsel_wbval.sv
// Forms the write-back-stage value: the preserved ALU result, or the
// load-data register after subword extraction by the load kind.
// Assumes XLEN >= 16.
module opsel_wbval
    import opsel_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            is_load,
    input  logic [2:0]      ldk,
    input  logic [XLEN-1:0] c1_val,
    input  logic [XLEN-1:0] lmdr_val,
    output logic [XLEN-1:0] wb_val
);

    logic [XLEN-1:0] ld_val;

    // Extract the addressed subword of the loaded word.
    always_comb begin
        case (ldk)
            LK_HALF_S: ld_val = XLEN'($signed(lmdr_val[15:0]));
            LK_HALF_U: ld_val = XLEN'(lmdr_val[15:0]);
            LK_BYTE_S: ld_val = XLEN'($signed(lmdr_val[7:0]));
            LK_BYTE_U: ld_val = XLEN'(lmdr_val[7:0]);
            default:   ld_val = lmdr_val;
        endcase
    end

    // Choose the candidate according to the slot's class.
    always_comb wb_val = is_load ? ld_val : c1_val;

endmodule

// File: rtl/opsel_operand_mux.sv
// Priority selector for one source operand.
// A memory-stage match wins over a write-back-stage match, which wins over
// the register file. Callers guarantee that the enables exclude index 0.
module opsel_operand_mux #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input  logic [AW-1:0]   src,
    input  logic            mem_en,
    input  logic [AW-1:0]   mem_idx,
    input  logic            wb_en,
    input  logic [AW-1:0]   wb_idx,
    input  logic [XLEN-1:0] rf_val,
    input  logic [XLEN-1:0] mem_val,
    input  logic [XLEN-1:0] wb_val,
    output logic [XLEN-1:0] sel_val
);

    logic mem_hit;
    logic wb_hit;

    // Compare the source against both producers and pick by age.
    always_comb begin
        mem_hit = mem_en && (mem_idx == src);
        wb_hit  = wb_en && (wb_idx == src);
        if (mem_hit)     sel_val = mem_val;
        else if (wb_hit) sel_val = wb_val;
        else             sel_val = rf_val;
    end

endmodule

// File: rtl/opsel_stage_top.sv
// Decode-stage operand bypass selector with its surrounding stage registers.
// One instruction per cycle enters decode. The execute-stage ALU result
// arrives on ex_result and the memory-stage raw word on mem_rdata.
// A load still in the memory stage is assumed to have been kept apart from
// its consumers by stall logic elsewhere, so it offers no candidate.
module opsel_stage_top
    import opsel_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_valid,
    input  logic [3:0]      id_cls,
    input  logic [2:0]      id_ldk,
    input  logic [AW-1:0]   id_dst,
    input  logic [AW-1:0]   id_src1,
    input  logic [AW-1:0]   id_src2,
    input  logic [XLEN-1:0] rf_rd1,
    input  logic [XLEN-1:0] rf_rd2,
    input  logic [XLEN-1:0] ex_result,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] opa,
    output logic [XLEN-1:0] opb,
    output logic            wb_we,
    output logic [AW-1:0]   wb_idx,
    output logic [XLEN-1:0] wb_data
);

    localparam int NOPND = 2;

    typedef struct packed {
        logic          valid;
        logic [3:0]    cls;
        logic [2:0]    ldk;
        logic [AW-1:0] dst;
    } stage_t;

    stage_t          ex_q, mem_q, wb_q;
    logic [XLEN-1:0] a_q, b_q, c_q, c1_q, lmdr_q;

    logic            mem_wr_en, mem_is_load, mem_fwd_en;
    logic [AW-1:0]   mem_wr_idx;
    logic            wb_wr_en, wb_is_load;
    logic [AW-1:0]   wb_wr_idx;
    logic [XLEN-1:0] wb_val;

    logic [AW-1:0]   src_idx [NOPND];
    logic [XLEN-1:0] rf_val  [NOPND];
    logic [XLEN-1:0] sel_val [NOPND];

    // Advance the instruction slots and the value registers by one stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q   <= '0;
            mem_q  <= '0;
            wb_q   <= '0;
            a_q    <= '0;
            b_q    <= '0;
            c_q    <= '0;
            c1_q   <= '0;
            lmdr_q <= '0;
        end else begin
            ex_q   <= '{valid: id_valid, cls: id_cls, ldk: id_ldk, dst: id_dst};
            mem_q  <= ex_q;
            wb_q   <= mem_q;
            a_q    <= sel_val[0];
            b_q    <= sel_val[1];
            c_q    <= ex_result;
            c1_q   <= c_q;
            lmdr_q <= mem_rdata;
        end
    end

    opsel_producer #(.NREG(NREG)) mem_prod_i (
        .valid   (mem_q.valid),
        .cls     (mem_q.cls),
        .dst     (mem_q.dst),
        .wr_en   (mem_wr_en),
        .wr_idx  (mem_wr_idx),
        .is_load (mem_is_load)
    );

    opsel_producer #(.NREG(NREG)) wb_prod_i (
        .valid   (wb_q.valid),
        .cls     (wb_q.cls),
        .dst     (wb_q.dst),
        .wr_en   (wb_wr_en),
        .wr_idx  (wb_wr_idx),
        .is_load (wb_is_load)
    );

    // A memory-stage load has no value ready, so only other writers forward.
    always_comb mem_fwd_en = mem_wr_en && !mem_is_load;

    opsel_wbval #(.XLEN(XLEN)) wbval_i (
        .is_load  (wb_is_load),
        .ldk      (wb_q.ldk),
        .c1_val   (c1_q),
        .lmdr_val (lmdr_q),
        .wb_val   (wb_val)
    );

    // Gather the per-operand source indices and register-file values.
    always_comb begin
        src_idx[0] = id_src1;
        src_idx[1] = id_src2;
        rf_val[0]  = rf_rd1;
        rf_val[1]  = rf_rd2;
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        opsel_operand_mux #(.XLEN(XLEN), .AW(AW)) mux_i (
            .src     (src_idx[g]),
            .mem_en  (mem_fwd_en),
            .mem_idx (mem_wr_idx),
            .wb_en   (wb_wr_en),
            .wb_idx  (wb_wr_idx),
            .rf_val  (rf_val[g]),
            .mem_val (c_q),
            .wb_val  (wb_val),
            .sel_val (sel_val[g])
        );
    end

    // Drive the operand and write-back outputs.
    always_comb begin
        opa     = a_q;
        opb     = b_q;
        wb_we   = wb_wr_en;
        wb_idx  = wb_wr_idx;
        wb_data = wb_val;
    end

endmodule

// File: rtl/opsel_stage_chk.sv
// Temporal checks on the bypass selector, attached to the top by bind.
// A saturating age counter gates the checks that look three edges back.
module opsel_stage_chk
    import opsel_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            id_valid,
    input logic [3:0]      id_cls,
    input logic [AW-1:0]   id_dst,
    input logic [AW-1:0]   id_src1,
    input logic [XLEN-1:0] rf_rd1,
    input logic [XLEN-1:0] opa,
    input logic [XLEN-1:0] opb,
    input logic            wb_we,
    input logic [AW-1:0]   wb_idx,
    input logic [XLEN-1:0] c_q,
    input logic            mem_fwd_en,
    input logic [AW-1:0]   mem_wr_idx
);

    logic [1:0] age;
    logic       warm;

    // Count edges since reset, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    always_comb warm = (age == 2'd3);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (opa == '0 && opb == '0 && !wb_we));

    // Forwarding from the memory stage into the latched first operand (R2).
    p_mem_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && mem_fwd_en && mem_wr_idx == id_src1) |=> (opa == $past(c_q)));

    p_src_zero_rf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && id_src1 == '0) |=> (opa == $past(rf_rd1)));

    p_bubble_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(!id_valid, 3)) |-> !wb_we);

    p_link_top_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(id_valid && id_cls == CL_LINK, 3))
            |-> (wb_we && wb_idx == AW'(NREG - 1)));

    p_alu_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(id_valid && id_cls == CL_ALU && id_dst != '0, 3))
            |-> (wb_we && wb_idx == $past(id_dst, 3)));

endmodule

bind opsel_stage_top opsel_stage_chk #(.XLEN(XLEN), .NREG(NREG)) chk_i (.*);

// File: tb/opsel_stage_top_tb_top.sv
// Random instruction streams checked against a behavioural register model.
module opsel_stage_top_tb_top;

    localparam int XLEN = 24;
    localparam int NREG = 8;
    localparam int AW   = $clog2(NREG);
    localparam int NINS = 3000;
    localparam int NI   = NINS + 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            id_valid;
    logic [3:0]      id_cls;
    logic [2:0]      id_ldk;
    logic [AW-1:0]   id_dst, id_src1, id_src2;
    logic [XLEN-1:0] rf_rd1, rf_rd2, ex_result, mem_rdata;
    logic [XLEN-1:0] opa, opb, wb_data;
    logic            wb_we;
    logic [AW-1:0]   wb_idx;

    opsel_stage_top #(.XLEN(XLEN), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
        .id_ldk(id_ldk), .id_dst(id_dst), .id_src1(id_src1), .id_src2(id_src2),
        .rf_rd1(rf_rd1), .rf_rd2(rf_rd2), .ex_result(ex_result),
        .mem_rdata(mem_rdata), .opa(opa), .opb(opb), .wb_we(wb_we),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    logic            vld  [NI];
    logic [3:0]      cls  [NI];
    logic [2:0]      ldk  [NI];
    logic [AW-1:0]   dst  [NI];
    logic [AW-1:0]   s1   [NI];
    logic [AW-1:0]   s2   [NI];
    logic [XLEN-1:0] res  [NI];
    logic [XLEN-1:0] raw  [NI];
    logic [XLEN-1:0] wval [NI];
    logic [XLEN-1:0] expa [NI];
    logic [XLEN-1:0] expb [NI];
    logic            wen  [NI];
    logic [AW-1:0]   widx [NI];
    logic [XLEN-1:0] rfhw [NREG];
    logic [XLEN-1:0] lag  [NREG];

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    function automatic bit writer_cls(logic [3:0] c);
        return c <= 4'd4;
    endfunction

    function automatic logic [XLEN-1:0] extract(logic [XLEN-1:0] w, logic [2:0] k);
        int v;
        case (k)
            3'd1: begin v = int'(w[15:0]); if (v >= 32768) v = v - 65536; end
            3'd2: v = int'(w[15:0]);
            3'd3: begin v = int'(w[7:0]); if (v >= 128) v = v - 256; end
            3'd4: v = int'(w[7:0]);
            default: return w;
        endcase
        return XLEN'(v);
    endfunction

    // Names the requirement that governs the value an operand should get.
    function automatic string opnd_tag(int c, logic [AW-1:0] s);
        bit m2, m3;
        if (s == '0) return "R9";
        m2 = (c >= 2) && wen[c-2] && widx[c-2] == s;
        m3 = (c >= 3) && wen[c-3] && widx[c-3] == s;
        if (m2 && m3) return "R4";
        if (m2) return (cls[c-2] == 4'd3) ? "R10" : "R2";
        if (m3) return (cls[c-3] == 4'd2) ? "R6" : ((cls[c-3] == 4'd3) ? "R10" : "R3");
        if (c >= 1 && wen[c-1] && widx[c-1] == s) return "R12";
        if ((c >= 2 && dst[c-2] == s) || (c >= 3 && dst[c-3] == s)) return "R8";
        return "R7";
    endfunction

    function automatic string wb_tag(int i);
        if (!vld[i] || !writer_cls(cls[i])) return "R8";
        if (!wen[i]) return "R9";
        if (cls[i] == 4'd3) return "R10";
        if (cls[i] == 4'd2) return "R6";
        return "R5";
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) begin
            rfhw[r] = '0;
            lag[r]  = '0;
        end
        rst_n = 1'b0;
        id_valid = 1'b0; id_cls = '0; id_ldk = '0; id_dst = '0;
        id_src1 = '0; id_src2 = '0; rf_rd1 = '1; rf_rd2 = '1;
        ex_result = '1; mem_rdata = '1;
        repeat (3) @(posedge clk);
        #6;
        check("R1", "opa after reset", 32'(opa), 32'd0);
        check("R1", "opb after reset", 32'(opb), 32'd0);
        check("R1", "wb_we after reset", 32'(wb_we), 32'd0);
        rst_n = 1'b1;
        ex_result = '0; mem_rdata = '0;

        for (int c = 0; c < NI; c++) begin
            @(posedge clk);
            #1;
            if (c >= 4 && wen[c-4]) rfhw[widx[c-4]] = wval[c-4];
            if (c >= 2 && wen[c-2]) lag[widx[c-2]] = wval[c-2];

            vld[c] = (c < NINS) ? (($urandom % 8) != 0) : 1'b0;
            cls[c] = 4'($urandom % 12);
            ldk[c] = 3'($urandom % 8);
            dst[c] = AW'($urandom % NREG);
            s1[c]  = AW'($urandom % NREG);
            s2[c]  = AW'($urandom % NREG);
            res[c] = XLEN'($urandom);
            raw[c] = XLEN'($urandom);
            // Stall stand-in: no consumer reads a load still in the memory stage.
            if (c >= 2 && wen[c-2] && cls[c-2] == 4'd2) begin
                if (s1[c] == widx[c-2]) s1[c] = '0;
                if (s2[c] == widx[c-2]) s2[c] = '0;
            end
            widx[c] = (cls[c] == 4'd3) ? AW'(NREG - 1) : dst[c];
            wen[c]  = vld[c] && writer_cls(cls[c]) && widx[c] != '0;
            wval[c] = (cls[c] == 4'd2) ? extract(raw[c], ldk[c]) : res[c];
            expa[c] = lag[s1[c]];
            expb[c] = lag[s2[c]];

            id_valid  = vld[c];
            id_cls    = cls[c];
            id_ldk    = ldk[c];
            id_dst    = dst[c];
            id_src1   = s1[c];
            id_src2   = s2[c];
            rf_rd1    = rfhw[s1[c]];
            rf_rd2    = rfhw[s2[c]];
            ex_result = (c >= 1) ? res[c-1] : '0;
            mem_rdata = (c >= 2) ? raw[c-2] : '0;

            #5;
            if (c >= 1 && vld[c-1]) begin
                check(opnd_tag(c - 1, s1[c-1]), "opa", 32'(opa), 32'(expa[c-1]));
                check(opnd_tag(c - 1, s2[c-1]), "opb", 32'(opb), 32'(expb[c-1]));
            end
            if (c >= 3) begin
                check(wb_tag(c - 3), "wb_we", 32'(wb_we), 32'(wen[c-3]));
                if (wen[c-3]) begin
                    check(wb_tag(c - 3), "wb_idx", 32'(wb_idx), 32'(widx[c-3]));
                    check(wb_tag(c - 3), "wb_data", 32'(wb_data), 32'(wval[c-3]));
                end
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule